// File: doc/BRIEF.md
# Cache Miss Dispatcher with Cleanup Guard

This block sits in the idle state of a cache controller and turns each lookup result into one action: answer a clean hit, hold a request back, or launch a miss toward the command side. A miss to a cacheable line goes into victim selection only when the previous cleanup (eviction notice) has drained. If that cleanup is still pending, the request stays in idle, no miss request is raised, and a stall counter advances. Gating the entry point this way means the victim state never has to block, which removes a circular wait between the eviction path and the refill path.

Uncacheable accesses stay strictly ordered. A new uncacheable access launches only when no earlier one is outstanding. An uncacheable read then waits for its response. An uncacheable write is posted and acknowledged at once, but it still holds the outstanding flag until its response returns. A lookup that reports a hit and a cleanup hit on the same line at the same time is treated as a collision and not as a hit. A miss whose line is still being cleaned up is held until that cleanup clears. Victim selection, refill and the command side are outside this block. It only raises the requests and walks the states around them.

Top module: `miss_dispatch`

## Requirements
- R1: After reset the state is idle (encoding 0), the miss request, uncached request and outstanding-uncached flag are all low, and the stall count is 0. State encodings: 0 idle, 1 victim, 2 miss wait, 3 uncached wait.
- R2: In idle, a valid request with a hit and no cleanup hit asserts rsp_valid in the same cycle, and the state stays idle.
- R3: In idle, a cacheable miss (no hit, no cleanup hit) while cleanup_pending is high raises no miss request, keeps the state idle, and adds one to the stall count on the next edge. The count saturates at its all-ones value.
- R4: In idle, a cacheable miss with cleanup_pending low pulses mbuf_init in the same cycle. On the next edge it sets the miss request, saves req_addr into miss_addr and enters the victim state. The victim state always moves to miss wait on the following edge, whatever cleanup_pending is.
- R5: The miss request stays high until miss_ack. Miss wait returns to idle on refill_done.
- R6: In idle, an uncacheable read with no outstanding uncached access pulses mbuf_init, then sets the uncached request and the outstanding flag, saves the address and enters uncached wait. unc_rsp clears the flag and returns to idle. unc_ack clears the uncached request.
- R7: An uncacheable write with no outstanding uncached access asserts rsp_valid and mbuf_init in the same cycle, sets the uncached request and the outstanding flag, and stays idle. Any uncacheable access seen while the flag is set is not launched and leaves the saved address unchanged.
- R8: A request whose lookup reports both hit and cleanup hit gives no rsp_valid and no launch, pulses collide and leaves the state idle.
- R9: A miss with cleanup hit set launches nothing, pulses no mbuf_init and leaves the stall count unchanged.
- R10: Outside idle, requests give no rsp_valid and do not change the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | CPU request present |
| req_write | input | 1 | Request is a store |
| req_addr | input | ADDR_W | Request address |
| lk_hit | input | 1 | Lookup hit |
| lk_cached | input | 1 | Address is cacheable |
| lk_cleanup_hit | input | 1 | Address matches a pending cleanup |
| cleanup_pending | input | 1 | A cleanup request has not drained yet |
| miss_ack | input | 1 | Command side took the miss request |
| refill_done | input | 1 | Refill finished |
| unc_ack | input | 1 | Command side took the uncached request |
| unc_rsp | input | 1 | Uncached response returned |
| rsp_valid | output | 1 | Request answered this cycle |
| collide | output | 1 | Hit and cleanup hit at the same time |
| mbuf_init | output | 1 | Initialise the miss buffer this cycle |
| miss_req | output | 1 | Miss request to the command side |
| unc_req | output | 1 | Uncached request to the command side |
| unc_busy | output | 1 | An uncached access is outstanding |
| miss_addr | output | ADDR_W | Saved address of the launched access |
| state | output | 2 | Current state |
| stall_count | output | CNT_W | Number of cycles stalled on a pending cleanup |

## Verification
The dispatcher is driven with every lookup combination in idle: a clean hit, a hit together with a cleanup hit, a miss on a line still being cleaned up, and a cacheable miss both with and without a pending cleanup. Comparing these cases shows that only the last one launches, and that only the pending-cleanup case counts a stall. Uncacheable reads and writes are sent back to back. This separates a posted write, which answers at once but still holds the ordering flag, from a read that waits, and shows that a second uncacheable access is held until the response returns. A request arriving during miss wait, together with a pending cleanup raised while in the victim state, confirms that the victim state never waits. A long run of stalls drives the counter into saturation.

// File: rtl/md_pkg.sv
package md_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_VICTIM = 2'd1,
        ST_MWAIT  = 2'd2,
        ST_UWAIT  = 2'd3
    } md_state_e;

    typedef enum logic [2:0] {
        ACT_NONE        = 3'd0,
        ACT_HIT         = 3'd1,
        ACT_COLLIDE     = 3'd2,
        ACT_LINE_BUSY   = 3'd3,
        ACT_CACHED_MISS = 3'd4,
        ACT_UNC_READ    = 3'd5,
        ACT_UNC_WRITE   = 3'd6
    } md_act_e;

endpackage

// File: rtl/md_classify.sv
module md_classify
    import md_pkg::*;
(
    input  logic    valid_i,
    input  logic    write_i,
    input  logic    hit_i,
    input  logic    cached_i,
    input  logic    cleanup_hit_i,
    output md_act_e act_o
);

    // Priority: collision first, then hit, then a line still under cleanup,
    // then the cacheable / uncacheable miss split.
    always_comb begin
        act_o = ACT_NONE;
        if (valid_i) begin
            if (hit_i && cleanup_hit_i)      act_o = ACT_COLLIDE;
            else if (hit_i)                  act_o = ACT_HIT;
            else if (cleanup_hit_i)          act_o = ACT_LINE_BUSY;
            else if (cached_i)               act_o = ACT_CACHED_MISS;
            else if (write_i)                act_o = ACT_UNC_WRITE;
            else                             act_o = ACT_UNC_READ;
        end
    end

endmodule

// File: rtl/md_stall_cnt.sv
module md_stall_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc_i && (cnt_q != CNT_MAX)) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    p_stall_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && cnt_q != CNT_MAX) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

    p_stall_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX) |=> cnt_q == CNT_MAX);

    p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !inc_i |=> $stable(cnt_q));

endmodule

// File: rtl/md_ctrl.sv
module md_ctrl
    import md_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  md_act_e           act_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic              cleanup_pending_i,
    input  logic              miss_ack_i,
    input  logic              refill_done_i,
    input  logic              unc_ack_i,
    input  logic              unc_rsp_i,
    output logic              rsp_valid_o,
    output logic              collide_o,
    output logic              mbuf_init_o,
    output logic              stall_inc_o,
    output logic              miss_req_o,
    output logic              unc_req_o,
    output logic              unc_busy_o,
    output logic [ADDR_W-1:0] addr_o,
    output md_state_e         state_o
);

    typedef struct packed {
        md_state_e         st;
        logic              mreq;
        logic              ureq;
        logic              ubusy;
        logic [ADDR_W-1:0] addr;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d       = ctl_q;
        rsp_valid_o = 1'b0;
        collide_o   = 1'b0;
        mbuf_init_o = 1'b0;
        stall_inc_o = 1'b0;

        // Handshakes from the command side clear first so a launch wins.
        if (miss_ack_i) ctl_d.mreq  = 1'b0;
        if (unc_ack_i)  ctl_d.ureq  = 1'b0;
        if (unc_rsp_i)  ctl_d.ubusy = 1'b0;

        unique case (ctl_q.st)
            ST_IDLE: begin
                unique case (act_i)
                    ACT_HIT:     rsp_valid_o = 1'b1;
                    ACT_COLLIDE: collide_o   = 1'b1;
                    ACT_CACHED_MISS: begin
                        if (cleanup_pending_i) begin
                            stall_inc_o = 1'b1;
                        end else begin
                            mbuf_init_o = 1'b1;
                            ctl_d.mreq  = 1'b1;
                            ctl_d.addr  = req_addr_i;
                            ctl_d.st    = ST_VICTIM;
                        end
                    end
                    ACT_UNC_READ: begin
                        if (!ctl_q.ubusy) begin
                            mbuf_init_o = 1'b1;
                            ctl_d.ureq  = 1'b1;
                            ctl_d.ubusy = 1'b1;
                            ctl_d.addr  = req_addr_i;
                            ctl_d.st    = ST_UWAIT;
                        end
                    end
                    ACT_UNC_WRITE: begin
                        if (!ctl_q.ubusy) begin
                            mbuf_init_o = 1'b1;
                            rsp_valid_o = 1'b1;
                            ctl_d.ureq  = 1'b1;
                            ctl_d.ubusy = 1'b1;
                            ctl_d.addr  = req_addr_i;
                        end
                    end
                    default: ;
                endcase
            end
            ST_VICTIM: ctl_d.st = ST_MWAIT;
            ST_MWAIT:  if (refill_done_i) ctl_d.st = ST_IDLE;
            ST_UWAIT:  if (unc_rsp_i)     ctl_d.st = ST_IDLE;
            default:   ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.st    <= ST_IDLE;
            ctl_q.mreq  <= 1'b0;
            ctl_q.ureq  <= 1'b0;
            ctl_q.ubusy <= 1'b0;
            ctl_q.addr  <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign miss_req_o = ctl_q.mreq;
    assign unc_req_o  = ctl_q.ureq;
    assign unc_busy_o = ctl_q.ubusy;
    assign addr_o     = ctl_q.addr;
    assign state_o    = ctl_q.st;

    p_pending_stays_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_IDLE && act_i == ACT_CACHED_MISS && cleanup_pending_i)
        |=> ctl_q.st == ST_IDLE);

    p_victim_no_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_VICTIM) |=> ctl_q.st == ST_MWAIT);

    p_miss_req_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.mreq && !miss_ack_i) |=> ctl_q.mreq);

    p_wait_implies_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_UWAIT) |-> ctl_q.ubusy);

    p_unc_ordered_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.ubusy && (act_i == ACT_UNC_READ || act_i == ACT_UNC_WRITE))
        |=> $stable(ctl_q.addr));

    p_collide_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_IDLE && act_i == ACT_COLLIDE)
        |=> (ctl_q.st == ST_IDLE && $stable(ctl_q.addr)));

    p_busy_no_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st != ST_IDLE) |-> !rsp_valid_o);

endmodule

// File: rtl/miss_dispatch.sv
module miss_dispatch
    import md_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              lk_hit,
    input  logic              lk_cached,
    input  logic              lk_cleanup_hit,
    input  logic              cleanup_pending,
    input  logic              miss_ack,
    input  logic              refill_done,
    input  logic              unc_ack,
    input  logic              unc_rsp,
    output logic              rsp_valid,
    output logic              collide,
    output logic              mbuf_init,
    output logic              miss_req,
    output logic              unc_req,
    output logic              unc_busy,
    output logic [ADDR_W-1:0] miss_addr,
    output logic [1:0]        state,
    output logic [CNT_W-1:0]  stall_count
);

    md_act_e   act;
    md_state_e st;
    logic      stall_inc;

    md_classify u_classify (
        .valid_i       (req_valid),
        .write_i       (req_write),
        .hit_i         (lk_hit),
        .cached_i      (lk_cached),
        .cleanup_hit_i (lk_cleanup_hit),
        .act_o         (act)
    );

    md_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk               (clk),
        .rst_n             (rst_n),
        .act_i             (act),
        .req_addr_i        (req_addr),
        .cleanup_pending_i (cleanup_pending),
        .miss_ack_i        (miss_ack),
        .refill_done_i     (refill_done),
        .unc_ack_i         (unc_ack),
        .unc_rsp_i         (unc_rsp),
        .rsp_valid_o       (rsp_valid),
        .collide_o         (collide),
        .mbuf_init_o       (mbuf_init),
        .stall_inc_o       (stall_inc),
        .miss_req_o        (miss_req),
        .unc_req_o         (unc_req),
        .unc_busy_o        (unc_busy),
        .addr_o            (miss_addr),
        .state_o           (st)
    );

    md_stall_cnt #(.CNT_W(CNT_W)) u_stall_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc_i (stall_inc),
        .cnt_o (stall_count)
    );

    assign state = st;

endmodule

// File: tb/miss_dispatch_tb.sv
module miss_dispatch_tb;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 32;
    localparam int CNT_W      = 4;

    localparam int K_ST = 0, K_MREQ = 1, K_UREQ = 2, K_BUSY = 3, K_RSP = 4,
                   K_CNT = 5, K_ADDR = 6, K_MBUF = 7, K_COLL = 8;

    typedef struct {
        int      cyc;
        int      kind;
        longint  val;
        string   tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 0, req_write = 0, lk_hit = 0, lk_cached = 0, lk_cleanup_hit = 0;
    logic cleanup_pending = 0, miss_ack = 0, refill_done = 0, unc_ack = 0, unc_rsp = 0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic rsp_valid, collide, mbuf_init, miss_req, unc_req, unc_busy;
    logic [ADDR_W-1:0] miss_addr;
    logic [1:0] state;
    logic [CNT_W-1:0] stall_count;

    int   cyc = 0;
    int   n_checks = 0;
    int   n_errors = 0;
    bit   reported = 0;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    miss_dispatch #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .lk_hit(lk_hit), .lk_cached(lk_cached),
        .lk_cleanup_hit(lk_cleanup_hit), .cleanup_pending(cleanup_pending),
        .miss_ack(miss_ack), .refill_done(refill_done), .unc_ack(unc_ack),
        .unc_rsp(unc_rsp), .rsp_valid(rsp_valid), .collide(collide),
        .mbuf_init(mbuf_init), .miss_req(miss_req), .unc_req(unc_req),
        .unc_busy(unc_busy), .miss_addr(miss_addr), .state(state),
        .stall_count(stall_count)
    );

    function automatic longint actual(int k);
        case (k)
            K_ST:    return longint'(state);
            K_MREQ:  return longint'(miss_req);
            K_UREQ:  return longint'(unc_req);
            K_BUSY:  return longint'(unc_busy);
            K_RSP:   return longint'(rsp_valid);
            K_CNT:   return longint'(stall_count);
            K_ADDR:  return longint'(miss_addr);
            K_MBUF:  return longint'(mbuf_init);
            default: return longint'(collide);
        endcase
    endfunction

    // Driver side: queue an expectation for this cycle (dly 0) or the next (dly 1).
    task automatic expect_val(int kind, longint val, int dly, string tag);
        exp_t e;
        e.cyc = cyc + dly; e.kind = kind; e.val = val; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic drive(logic v, logic w, logic [ADDR_W-1:0] a, logic h, logic c,
                         logic ch, logic cp, logic ma, logic rd, logic ua, logic ur);
        @(negedge clk);
        req_valid = v; req_write = w; req_addr = a; lk_hit = h; lk_cached = c;
        lk_cleanup_hit = ch; cleanup_pending = cp; miss_ack = ma;
        refill_done = rd; unc_ack = ua; unc_rsp = ur;
    endtask

    task automatic quiet();
        drive(0, 0, '0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    // Monitor: compare every expectation that falls due in this cycle.
    always begin
        @(negedge clk);
        #2;
        begin
            exp_t keep[$];
            keep = {};
            foreach (sb[i]) begin
                if (sb[i].cyc == cyc) begin
                    longint a;
                    a = actual(sb[i].kind);
                    n_checks++;
                    if (a !== sb[i].val) begin
                        n_errors++;
                        $display("FAIL %s kind=%0d actual=%0h expected=%0h",
                                 sb[i].tag, sb[i].kind, a, sb[i].val);
                    end
                end else begin
                    keep.push_back(sb[i]);
                end
            end
            sb = keep;
        end
    end

    task automatic finish_run();
        if (!reported) begin
            reported = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        quiet();
        expect_val(K_ST, 0, 0, "R1");
        expect_val(K_MREQ, 0, 0, "R1");
        expect_val(K_UREQ, 0, 0, "R1");
        expect_val(K_BUSY, 0, 0, "R1");
        expect_val(K_CNT, 0, 0, "R1");

        // R2: clean hit
        drive(1, 0, 32'h100, 1, 1, 0, 0, 0, 0, 0, 0);
        expect_val(K_RSP, 1, 0, "R2");
        expect_val(K_MBUF, 0, 0, "R2");
        expect_val(K_ST, 0, 1, "R2");

        // R8: hit together with cleanup hit
        drive(1, 0, 32'h104, 1, 1, 1, 0, 0, 0, 0, 0);
        expect_val(K_RSP, 0, 0, "R8");
        expect_val(K_COLL, 1, 0, "R8");
        expect_val(K_MBUF, 0, 0, "R8");
        expect_val(K_ST, 0, 1, "R8");
        expect_val(K_MREQ, 0, 1, "R8");

        // R9: miss on a line still being cleaned up, with a cleanup pending
        drive(1, 0, 32'h108, 0, 1, 1, 1, 0, 0, 0, 0);
        expect_val(K_MBUF, 0, 0, "R9");
        expect_val(K_RSP, 0, 0, "R9");
        expect_val(K_CNT, 0, 1, "R9");
        expect_val(K_MREQ, 0, 1, "R9");
        expect_val(K_ST, 0, 1, "R9");

        // R3: cacheable miss stalled by a pending cleanup, three cycles
        for (int k = 1; k <= 3; k++) begin
            drive(1, 0, 32'h200, 0, 1, 0, 1, 0, 0, 0, 0);
            expect_val(K_MBUF, 0, 0, "R3");
            expect_val(K_CNT, k, 1, "R3");
            expect_val(K_MREQ, 0, 1, "R3");
            expect_val(K_ST, 0, 1, "R3");
        end

        // R4: cleanup drained, miss launches into victim selection
        drive(1, 0, 32'h1234, 0, 1, 0, 0, 0, 0, 0, 0);
        expect_val(K_MBUF, 1, 0, "R4");
        expect_val(K_ST, 1, 1, "R4");
        expect_val(K_MREQ, 1, 1, "R4");
        expect_val(K_ADDR, 32'h1234, 1, "R4");
        expect_val(K_CNT, 3, 1, "R4");
        // R4: victim moves on even with a new cleanup pending
        drive(0, 0, '0, 0, 0, 0, 1, 0, 0, 0, 0);
        expect_val(K_ST, 2, 1, "R4");

        // R10: request during miss wait is ignored
        drive(1, 0, 32'h300, 1, 1, 0, 0, 0, 0, 0, 0);
        expect_val(K_RSP, 0, 0, "R10");
        expect_val(K_ST, 2, 1, "R10");
        expect_val(K_MREQ, 1, 1, "R5");

        // R5: ack drops the miss request; refill returns to idle
        drive(0, 0, '0, 0, 0, 0, 0, 1, 0, 0, 0);
        expect_val(K_MREQ, 0, 1, "R5");
        expect_val(K_ST, 2, 1, "R5");
        drive(0, 0, '0, 0, 0, 0, 0, 0, 1, 0, 0);
        expect_val(K_ST, 0, 1, "R5");

        // R6: uncacheable read
        drive(1, 0, 32'hB0, 0, 0, 0, 0, 0, 0, 0, 0);
        expect_val(K_MBUF, 1, 0, "R6");
        expect_val(K_RSP, 0, 0, "R6");
        expect_val(K_ST, 3, 1, "R6");
        expect_val(K_UREQ, 1, 1, "R6");
        expect_val(K_BUSY, 1, 1, "R6");
        expect_val(K_ADDR, 32'hB0, 1, "R6");
        drive(0, 0, '0, 0, 0, 0, 0, 0, 0, 1, 0);
        expect_val(K_UREQ, 0, 1, "R6");
        expect_val(K_ST, 3, 1, "R6");
        drive(0, 0, '0, 0, 0, 0, 0, 0, 0, 0, 1);
        expect_val(K_ST, 0, 1, "R6");
        expect_val(K_BUSY, 0, 1, "R6");

        // R7: posted uncacheable write
        drive(1, 1, 32'hC0, 0, 0, 0, 0, 0, 0, 0, 0);
        expect_val(K_RSP, 1, 0, "R7");
        expect_val(K_MBUF, 1, 0, "R7");
        expect_val(K_ST, 0, 1, "R7");
        expect_val(K_BUSY, 1, 1, "R7");
        expect_val(K_UREQ, 1, 1, "R7");
        expect_val(K_ADDR, 32'hC0, 1, "R7");
        // R7: a read while the write is outstanding is held
        drive(1, 0, 32'hD0, 0, 0, 0, 0, 0, 0, 0, 0);
        expect_val(K_RSP, 0, 0, "R7");
        expect_val(K_MBUF, 0, 0, "R7");
        expect_val(K_ST, 0, 1, "R7");
        expect_val(K_ADDR, 32'hC0, 1, "R7");
        // R7: a second write is held as well
        drive(1, 1, 32'hE0, 0, 0, 0, 0, 0, 0, 0, 0);
        expect_val(K_RSP, 0, 0, "R7");
        expect_val(K_ADDR, 32'hC0, 1, "R7");
        drive(0, 0, '0, 0, 0, 0, 0, 0, 0, 1, 1);
        expect_val(K_BUSY, 0, 1, "R7");
        expect_val(K_UREQ, 0, 1, "R7");
        drive(1, 0, 32'hD0, 0, 0, 0, 0, 0, 0, 0, 0);
        expect_val(K_MBUF, 1, 0, "R7");
        expect_val(K_ST, 3, 1, "R7");
        expect_val(K_ADDR, 32'hD0, 1, "R7");
        drive(0, 0, '0, 0, 0, 0, 0, 0, 0, 1, 1);
        expect_val(K_ST, 0, 1, "R6");

        // R3: stall counter saturates at 15 (CNT_W = 4), starting from 3
        for (int k = 4; k <= 17; k++) begin
            drive(1, 0, 32'h400, 0, 1, 0, 1, 0, 0, 0, 0);
            expect_val(K_CNT, (k > 15) ? 15 : k, 1, "R3");
        end
        quiet();
        expect_val(K_ST, 0, 1, "R3");
        expect_val(K_CNT, 15, 1, "R3");

        repeat (3) quiet();
        if (sb.size() != 0) begin
            n_errors++;
            $display("FAIL scoreboard actual=%0d expected=0 pending", sb.size());
        end
        finish_run();
    end

endmodule